// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the control unit of a one-instruction-per-cycle processor. It looks at a 32-bit instruction word and, with no storage and no clock, produces every control point the datapath needs for that instruction: register destination select, ALU operand select, immediate extension mode, write-back source, memory write enable, register write enable, next-PC select and a 2-bit ALU operation.

Six instructions are recognised. Two are register-register operations, add and subtract, which share one major opcode and differ by their function field. The other four are OR with an immediate, load word, store word and branch-if-equal. Logical immediates are zero-extended. Memory and branch offsets are sign-extended. Every other encoding decodes to all-zero controls, so an unknown instruction writes neither the register file nor memory and the PC advances by one word.

Outputs that do not matter for a given instruction are driven to 0, so every output has one exact expected value for every input.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: The major opcode is taken from instruction bits 31:26 and the function field from bits 5:0. Bits 25:6 have no effect on any output.
- R2: Opcode 000000 with function 100000 (add) gives dst_sel_rd=1, alu_imm_sel=0, imm_sign_ext=0, wb_from_mem=0, mem_write=0, reg_write=1, pc_take_branch=0, alu_op=00 (add).
- R3: Opcode 000000 with function 100010 (subtract) gives the same controls as R2, except that alu_op=01 (subtract).
- R4: Opcode 001101 (OR with zero-extended immediate) gives dst_sel_rd=0, alu_imm_sel=1, imm_sign_ext=0, wb_from_mem=0, mem_write=0, reg_write=1, pc_take_branch=0, alu_op=10 (OR).
- R5: Opcode 100011 (load word) gives dst_sel_rd=0, alu_imm_sel=1, imm_sign_ext=1, wb_from_mem=1, mem_write=0, reg_write=1, pc_take_branch=0, alu_op=00.
- R6: Opcode 101011 (store word) gives dst_sel_rd=0, alu_imm_sel=1, imm_sign_ext=1, wb_from_mem=0, mem_write=1, reg_write=0, pc_take_branch=0, alu_op=00.
- R7: Opcode 000100 (branch if equal) gives dst_sel_rd=0, alu_imm_sel=0, imm_sign_ext=1, wb_from_mem=0, mem_write=0, reg_write=0, pc_take_branch=1, alu_op=01.
- R8: Every other opcode, and opcode 000000 with any function other than 100000 or 100010, drives all outputs to 0.
- R9: The function field is ignored when the opcode is not 000000. For example, opcode 001101 decodes as R4 whatever bits 5:0 hold.
- R10: No decode asserts more than one of reg_write, mem_write and pc_take_branch. wb_from_mem=1 only occurs together with reg_write=1 and alu_imm_sel=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being executed |
| dst_sel_rd | output | 1 | 1 selects bits 15:11 as destination register, 0 selects bits 20:16 |
| alu_imm_sel | output | 1 | 1 feeds the extended immediate to ALU operand B |
| imm_sign_ext | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| wb_from_mem | output | 1 | 1 writes back memory data, 0 writes back the ALU result |
| mem_write | output | 1 | Data memory write enable |
| reg_write | output | 1 | Register file write enable |
| pc_take_branch | output | 1 | 1 selects the branch target path for the next PC, 0 selects PC+4 |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 OR |

## Verification
The hardest cases to reach are those where a function-field pattern that means something for opcode 000000 appears under a different opcode, and near-miss function codes under opcode 000000. A directed test would rarely choose either. The bench sweeps all 4096 combinations of opcode and function field, so each of these collisions is decoded at least once. It also varies bits 25:6 with a scrambled pattern for each combination, which shows that the middle of the word never affects the decode.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int N_OPS = 6;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_ADD  = 3'd1,
    K_SUB  = 3'd2,
    K_ORI  = 3'd3,
    K_LW   = 3'd4,
    K_SW   = 3'd5,
    K_BEQ  = 3'd6
  } kind_e;

  typedef struct packed {
    logic    dst_rd;
    logic    imm_b;
    logic    sext;
    logic    wb_mem;
    logic    mem_we;
    logic    reg_we;
    logic    br;
    alu_op_e alu;
  } ctrl_t;

  // Recognition table, slot i corresponds to kind i+1
  localparam logic [N_OPS*OP_W-1:0] OPC_TAB = {
    6'b000100, 6'b101011, 6'b100011, 6'b001101, 6'b000000, 6'b000000};
  localparam logic [N_OPS*FN_W-1:0] FN_TAB = {
    6'b000000, 6'b000000, 6'b000000, 6'b000000, 6'b100010, 6'b100000};
  localparam logic [N_OPS-1:0] FN_USED = 6'b000011;

  function automatic ctrl_t ctrl_of(kind_e k);
    ctrl_t c;
    c = '0;
    case (k)
      K_ADD: begin c.dst_rd = 1'b1; c.reg_we = 1'b1; c.alu = ALU_ADD; end
      K_SUB: begin c.dst_rd = 1'b1; c.reg_we = 1'b1; c.alu = ALU_SUB; end
      K_ORI: begin c.imm_b = 1'b1; c.reg_we = 1'b1; c.alu = ALU_OR; end
      K_LW:  begin c.imm_b = 1'b1; c.sext = 1'b1; c.wb_mem = 1'b1; c.reg_we = 1'b1; end
      K_SW:  begin c.imm_b = 1'b1; c.sext = 1'b1; c.mem_we = 1'b1; end
      K_BEQ: begin c.sext = 1'b1; c.br = 1'b1; c.alu = ALU_SUB; end
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sc_op_classify.sv
module sc_op_classify
  import sc_ctrl_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int FNW = FN_W
) (
  input  logic [OPW-1:0] opcode,
  input  logic [FNW-1:0] funct,
  output logic [N_OPS-1:0] hit,
  output kind_e          kind
);
  for (genvar i = 0; i < N_OPS; i++) begin : g_slot
    localparam logic [OPW-1:0] OPC = OPC_TAB[i*OP_W +: OP_W];
    localparam logic [FNW-1:0] FN  = FN_TAB[i*FN_W +: FN_W];
    if (FN_USED[i]) begin : g_fn
      assign hit[i] = (opcode == OPC) && (funct == FN);
    end else begin : g_nofn
      assign hit[i] = (opcode == OPC);
    end
  end

  always_comb begin
    kind = K_NONE;
    for (int i = 0; i < N_OPS; i++)
      if (hit[i]) kind = kind_e'(i + 1);
  end

  // R8: at most one slot may match any encoding
  always_comb begin
    assert_single_match_R8: assert ($onehot0(hit))
      else $error("several decode slots matched");
  end
endmodule

// File: rtl/sc_ctrl_encode.sv
module sc_ctrl_encode
  import sc_ctrl_pkg::*;
(
  input  kind_e kind,
  output ctrl_t ctrl
);
  always_comb ctrl = ctrl_of(kind);

  always_comb begin
    assert_one_side_effect_R10: assert ($countones({ctrl.reg_we, ctrl.mem_we, ctrl.br}) <= 1)
      else $error("more than one of register write, memory write, branch");
    assert_load_path_R10: assert (!ctrl.wb_mem || (ctrl.reg_we && ctrl.imm_b))
      else $error("memory write-back without register write and immediate operand");
    assert_unknown_quiet_R8: assert (kind != K_NONE || ctrl == '0)
      else $error("unknown encoding produced nonzero controls");
  end
endmodule

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder
  import sc_ctrl_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic               dst_sel_rd,
  output logic               alu_imm_sel,
  output logic               imm_sign_ext,
  output logic               wb_from_mem,
  output logic               mem_write,
  output logic               reg_write,
  output logic               pc_take_branch,
  output logic [1:0]         alu_op
);
  localparam int OP_LSB = INSTR_W - OP_W;

  logic [OP_W-1:0]  opcode;
  logic [FN_W-1:0]  funct;
  logic [N_OPS-1:0] slot_hit;
  kind_e            kind;
  ctrl_t            ctrl;
  logic             unused_mid_bits;

  assign opcode          = instr_i[INSTR_W-1:OP_LSB];
  assign funct           = instr_i[FN_W-1:0];
  assign unused_mid_bits = ^instr_i[OP_LSB-1:FN_W];

  sc_op_classify #(.OPW(OP_W), .FNW(FN_W)) u_classify (
    .opcode(opcode), .funct(funct), .hit(slot_hit), .kind(kind));

  sc_ctrl_encode u_encode (.kind(kind), .ctrl(ctrl));

  assign dst_sel_rd     = ctrl.dst_rd;
  assign alu_imm_sel    = ctrl.imm_b;
  assign imm_sign_ext   = ctrl.sext;
  assign wb_from_mem    = ctrl.wb_mem;
  assign mem_write      = ctrl.mem_we;
  assign reg_write      = ctrl.reg_we;
  assign pc_take_branch = ctrl.br;
  assign alu_op         = ctrl.alu;

  always_comb begin
    // R7: the branch path is only taken when the branch opcode is present
    assert_branch_opcode_R7: assert (!pc_take_branch || opcode == 6'b000100)
      else $error("branch select without branch opcode");
    // R6: memory writes come only from the store opcode
    assert_store_opcode_R6: assert (!mem_write || opcode == 6'b101011)
      else $error("memory write without store opcode");
  end
endmodule

// File: tb/sc_ctrl_decoder_bench.sv
module sc_ctrl_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'h0;
  logic        d_rd, a_imm, sx, wbm, mw, rw, br;
  logic [1:0]  aop;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sc_ctrl_decoder u_sc_ctrl_decoder (
    .instr_i(instr), .dst_sel_rd(d_rd), .alu_imm_sel(a_imm), .imm_sign_ext(sx),
    .wb_from_mem(wbm), .mem_write(mw), .reg_write(rw), .pc_take_branch(br),
    .alu_op(aop));

  // Expected bundle {rd,imm,sext,wbmem,memwe,regwe,br,alu[1:0]} from the requirements
  function automatic logic [8:0] expect_of(input int op, input int fn, output string req);
    req = "R8";
    expect_of = 9'b0;
    if (op == 0 && fn == 32)      begin req = "R2"; expect_of = 9'b1_0_0_0_0_1_0_00; end
    else if (op == 0 && fn == 34) begin req = "R3"; expect_of = 9'b1_0_0_0_0_1_0_01; end
    else if (op == 13)            begin req = "R4_R9"; expect_of = 9'b0_1_0_0_0_1_0_10; end
    else if (op == 35)            begin req = "R5_R9"; expect_of = 9'b0_1_1_1_0_1_0_00; end
    else if (op == 43)            begin req = "R6_R9"; expect_of = 9'b0_1_1_0_1_0_0_00; end
    else if (op == 4)             begin req = "R7_R9"; expect_of = 9'b0_0_1_0_0_0_1_01; end
  endfunction

  task automatic check(input logic [8:0] exp, input string req);
    logic [8:0] act;
    act = {d_rd, a_imm, sx, wbm, mw, rw, br, aop};
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s instr=%h actual=%b expected=%b", req, instr, act, exp);
    end
  endtask

  initial begin
    string req;
    logic [8:0] e;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(9'b0, "R8_initial");
    // R1 R2..R9: every opcode/funct pair, mid bits scrambled
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        @(posedge clk);
        instr = {op[5:0], 20'(op * 40503 + fn * 2654435 + 17), fn[5:0]};
        @(negedge clk);
        e = expect_of(op, fn, req);
        check(e, req);
      end
    end
    // R1: same opcode/funct, opposite mid-bit patterns
    for (int k = 0; k < 6; k++) begin
      int ops [6] = '{0, 0, 13, 35, 43, 4};
      int fns [6] = '{32, 34, 7, 0, 63, 32};
      for (int p = 0; p < 2; p++) begin
        @(posedge clk);
        instr = {ops[k][5:0], (p == 0) ? 20'h00000 : 20'hFFFFF, fns[k][5:0]};
        @(negedge clk);
        e = expect_of(ops[k], fns[k], req);
        check(e, "R1");
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule